// File: doc/BRIEF.md
# I2C Target with General Call and High-Speed Tracking

This block is a synchronous I2C target. It samples SCL and SDA with the system clock, detects START, repeated START and STOP, and shifts address and data bytes through a bit counter. SDA is driven open-drain: the block only ever asserts an output enable that pulls the line low. A small internal register file is reached over the bus through an auto-incrementing pointer. A write transfer loads the pointer from its first data byte and then writes registers. A read transfer returns registers starting at the pointer.

The 7-bit target address comes from external address pins. It is captured once after reset and again only when a general call command asks for it. Command 0x04 recaptures the pins. Command 0x06 recaptures the pins and returns every register and the pointer to their power-up values. A high-speed master code is never acknowledged. It raises a speed-mode flag for downstream filter logic, and the flag stays set until the next STOP.

Top module: `i2c_gc_target`

## Requirements
- R1: A START (SDA falling while SCL is high) releases SDA and begins reception of a new address byte from any state, including a repeated START inside a transfer.
- R2: A STOP (SDA rising while SCL is high) releases SDA and returns the target to idle. After reset, SDA is released and the speed flag is low.
- R3: An address byte whose upper seven bits equal the own address is acknowledged by holding SDA low through the whole high phase of the ninth clock. With R/W=0 the first data byte loads the pointer, each later byte writes the register at the pointer, and every such byte is acknowledged.
- R4: An address byte that matches neither the own address nor the general call value 0x00 is not acknowledged, and the target stays silent on all later bytes until the next START or STOP.
- R5: With R/W=1 the target sends the register at the pointer MSB first, one byte per master acknowledge, and the pointer advances after each byte sent.
- R6: A master NACK after a read byte ends the transfer: SDA stays released, and later clocks read as all ones until the next START or STOP.
- R7: After each byte written or read, the pointer advances by one and wraps from NUM_REGS-1 to 0.
- R8: Address byte 0x00 is acknowledged as a general call, and every following byte is acknowledged as a command. Command 0x04 loads the address pins into the own address and leaves the registers unchanged.
- R9: General call command 0x06 loads the address pins and resets register i to 0xA0+i and the pointer to 0.
- R10: An address byte of the form 00001xxx (0x08 to 0x0F) is not acknowledged, and it sets the speed-mode output high.
- R11: The speed-mode output stays high through repeated STARTs and later transfers, and it is cleared by a STOP.
- R12: The target changes its SDA output enable only while the sampled SCL is low.
- R13: The own address is taken from the address pins after reset, and it does not follow later pin changes until a general call latch command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pins_i | input | 7 | Address pin levels, captured on command |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| hs_mode_o | output | 1 | High-speed mode flag for the filter logic |

## Verification
On every cycle the assertions check four things. The output enable moves only while the sampled SCL is low. START and STOP always release the line and reset the state. The ignore state keeps SDA released. The speed flag never rises together with an acknowledge and never falls except at a STOP. Only the bench scenarios can show byte-level results: which addresses are acknowledged, the register contents and pointer wrap seen through reads, that address changes wait for a general call command, and that command 0x06 restores the power-up values. The bench also compares the speed flag on every clock against its own model of the bus.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_GC,
    ST_PTR,
    ST_WR,
    ST_RD,
    ST_IGNORE
  } st_e;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_CMD_LATCH = 8'h04;
  localparam logic [7:0] GC_CMD_RESET = 8'h06;
  localparam logic [4:0] HS_CODE_HI   = 5'b00001;

  function automatic logic [7:0] reg_rst_val(input int base, input int idx);
    return 8'(base + idx);
  endfunction
endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int CHAIN = STAGES + 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // bus idles high
      else         chain_q <= {chain_q[CHAIN-2:0], d_i[b]};
    end
    assign lvl_o[b]  = chain_q[CHAIN-2];
    assign rise_o[b] = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
    assign fall_o[b] = ~chain_q[CHAIN-2] & chain_q[CHAIN-1];
  end
endmodule

// File: rtl/i2c_gc_regfile.sv
module i2c_gc_regfile #(
  parameter int NUM_REGS = 4,
  parameter int RST_BASE = 'hA0,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RV = i2c_gc_pkg::reg_rst_val(RST_BASE, i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[i] <= RV;
      else if (clr_i)                              regs_q[i] <= RV;
      else if (we_i && waddr_i == PTR_W'(i))       regs_q[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/i2c_gc_decode.sv
module i2c_gc_decode
  import i2c_gc_pkg::*;
(
  input  st_e               st_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] own_i,
  output logic              ack_o,
  output st_e               nxt_o,
  output logic              hs_set_o,
  output logic              ptr_ld_o,
  output logic              wr_o,
  output logic              rd_adv_o,
  output logic              latch_o,
  output logic              soft_rst_o
);
  always_comb begin
    ack_o      = 1'b0;
    nxt_o      = ST_IGNORE;
    hs_set_o   = 1'b0;
    ptr_ld_o   = 1'b0;
    wr_o       = 1'b0;
    rd_adv_o   = 1'b0;
    latch_o    = 1'b0;
    soft_rst_o = 1'b0;
    unique case (st_i)
      ST_ADDR: begin
        if (byte_i[7:3] == HS_CODE_HI) begin
          hs_set_o = 1'b1;  // master code: never acknowledged
        end else if (byte_i == GC_ADDR_BYTE) begin
          ack_o = 1'b1;
          nxt_o = ST_GC;
        end else if (byte_i[7:1] == own_i) begin
          ack_o = 1'b1;
          nxt_o = byte_i[0] ? ST_RD : ST_PTR;
        end
      end
      ST_GC: begin
        ack_o      = 1'b1;
        nxt_o      = ST_GC;
        latch_o    = (byte_i == GC_CMD_LATCH) || (byte_i == GC_CMD_RESET);
        soft_rst_o = (byte_i == GC_CMD_RESET);
      end
      ST_PTR: begin
        ack_o    = 1'b1;
        nxt_o    = ST_WR;
        ptr_ld_o = 1'b1;
      end
      ST_WR: begin
        ack_o = 1'b1;
        nxt_o = ST_WR;
        wr_o  = 1'b1;
      end
      ST_RD: begin
        nxt_o    = ST_RD;
        rd_adv_o = 1'b1;
      end
      default: nxt_o = ST_IGNORE;
    endcase
  end
endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2c_gc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int RST_BASE = 'hA0,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  output logic              sda_oe_o,
  output logic              hs_mode_o
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;

  logic [1:0] lvl, rise, fall;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_gc_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_det = scl_lvl & ~scl_rise & fall[1];
  assign stop_det  = scl_lvl & ~scl_rise & rise[1];

  st_e               st_q, nxt_q, dec_nxt;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic              oe_q, hs_q;
  logic [PTR_W-1:0]  ptr_q, ptr_inc;
  logic [ADDR_W-1:0] own_q;
  logic              own_load_q;
  logic [7:0]        rd_data;
  logic              active, ev_byte;
  logic dec_ack, dec_hs, dec_ptr_ld, dec_wr, dec_rd_adv, dec_latch, dec_soft_rst;

  assign active  = (st_q != ST_IDLE) && (st_q != ST_IGNORE);
  assign ev_byte = active && scl_fall && (cnt_q == BIT_LAST) && !start_det && !stop_det;

  i2c_gc_decode u_dec (
    .st_i       (st_q),
    .byte_i     (sh_q),
    .own_i      (own_q),
    .ack_o      (dec_ack),
    .nxt_o      (dec_nxt),
    .hs_set_o   (dec_hs),
    .ptr_ld_o   (dec_ptr_ld),
    .wr_o       (dec_wr),
    .rd_adv_o   (dec_rd_adv),
    .latch_o    (dec_latch),
    .soft_rst_o (dec_soft_rst)
  );

  i2c_gc_regfile #(.NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ev_byte & dec_soft_rst),
    .we_i    (ev_byte & dec_wr),
    .waddr_i (ptr_q),
    .wdata_i (sh_q),
    .raddr_i (ptr_q),
    .rdata_o (rd_data)
  );

  assign ptr_inc = (ptr_q == PTR_W'(NUM_REGS - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ev_byte) begin
      if (dec_soft_rst)                 ptr_q <= '0;
      else if (dec_ptr_ld)              ptr_q <= sh_q[PTR_W-1:0];
      else if (dec_wr || dec_rd_adv)    ptr_q <= ptr_inc;
    end
  end

  // own address: captured on the first clock after reset, then only on command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q      <= '0;
      own_load_q <= 1'b1;
    end else begin
      own_load_q <= 1'b0;
      if (own_load_q || (ev_byte && dec_latch)) own_q <= addr_pins_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      nxt_q <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      tx_q  <= '1;
      oe_q  <= 1'b0;
      hs_q  <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
      hs_q  <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt_q < BIT_LAST) sh_q <= {sh_q[6:0], sda_lvl};
        if (cnt_q < BIT_ACK)  cnt_q <= cnt_q + 1'b1;
        // master NACK on a read byte
        if (cnt_q == BIT_LAST && st_q == ST_RD && sda_lvl) nxt_q <= ST_IGNORE;
      end else if (scl_fall) begin
        if (cnt_q == BIT_LAST) begin
          oe_q  <= dec_ack;
          nxt_q <= dec_nxt;
          if (dec_hs) hs_q <= 1'b1;
        end else if (cnt_q == BIT_ACK) begin
          cnt_q <= '0;
          st_q  <= nxt_q;
          if (nxt_q == ST_RD) begin
            oe_q <= ~rd_data[7];
            tx_q <= {rd_data[6:0], 1'b1};
          end else begin
            oe_q <= 1'b0;
          end
        end else if (st_q == ST_RD && cnt_q != '0) begin
          oe_q <= ~tx_q[7];
          tx_q <= {tx_q[6:0], 1'b1};
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign hs_mode_o = hs_q;
endmodule

// File: rtl/i2c_gc_target_chk.sv
module i2c_gc_target_chk
  import i2c_gc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic scl_lvl,
  input logic start_det,
  input logic stop_det,
  input st_e  st_q,
  input logic sda_oe_o,
  input logic hs_mode_o
);
  p_oe_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_lvl));

  p_start_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st_q == ST_ADDR && !sda_oe_o));

  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st_q == ST_IDLE && !sda_oe_o && !hs_mode_o));

  p_ignore_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGNORE) |-> !sda_oe_o);

  p_hs_no_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> !sda_oe_o);

  p_hs_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_mode_o && !stop_det) |=> hs_mode_o);
endmodule

bind i2c_gc_target i2c_gc_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_lvl   (scl_lvl),
  .start_det (start_det),
  .stop_det  (stop_det),
  .st_q      (st_q),
  .sda_oe_o  (sda_oe_o),
  .hs_mode_o (hs_mode_o)
);

// File: tb/i2c_gc_target_tb.sv
`timescale 1ns/100ps
module i2c_gc_target_tb;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] pins = 7'h48;
  logic sda_oe, hs_mode, sda_bus;
  int total = 0, bad = 0;
  bit done = 0;
  bit mon_hold = 1'b0;
  logic hs_model = 1'b0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_gc_target u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .addr_pins_i (pins),
    .sda_oe_o    (sda_oe),
    .hs_mode_o   (hs_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison: speed flag (R11) and drive timing (R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!mon_hold && hs_mode !== hs_model) begin
        bad++;
        $display("FAIL R11 actual=%0h expected=%0h", hs_mode, hs_model);
      end
      if (sda_oe !== oe_prev && m_scl) begin
        bad++;
        $display("FAIL R12 actual=%0h expected=%0h", sda_oe, oe_prev);
      end
      oe_prev = sda_oe;
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    m_sda = 1'b1; w(H);
    m_scl = 1'b1; w(H);
    m_sda = 1'b0; w(H);
    m_scl = 1'b0; w(2);
  endtask

  task automatic do_stop;
    mon_hold = 1'b1;
    m_sda = 1'b0; w(H);
    m_scl = 1'b1; w(H);
    m_sda = 1'b1; w(H);
    hs_model = 1'b0;
    w(4);
    mon_hold = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(H);
      m_scl = 1'b1; w(H);
      m_scl = 1'b0; w(2);
    end
    m_sda = 1'b1; w(H);
    m_scl = 1'b1; w(2);
    ack = ~sda_bus;
    w(H/2 - 2);
    ack = ack & ~sda_bus;
    w(H/2 - 1);
    ack = ack & ~sda_bus;  // held low across the high phase
    w(1);
    m_scl = 1'b0; w(2);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; w(H);
      m_scl = 1'b1; w(H/2);
      b[i] = sda_bus;
      w(H/2);
      m_scl = 1'b0; w(2);
    end
    m_sda = ~ack_it; w(H);
    m_scl = 1'b1; w(H);
    m_scl = 1'b0; w(2);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    w(5);
    rst_n = 1'b1;
    w(5);
    chk(sda_oe == 1'b0, "R2 reset oe", sda_oe, 0);
    chk(hs_mode == 1'b0, "R2 reset hs", hs_mode, 0);

    // write pointer 1, then two registers
    do_start;
    send_byte(8'h90, a); chk(a == 1, "R13 addr from pins", a, 1);
    send_byte(8'h01, a); chk(a == 1, "R3 ptr ack", a, 1);
    send_byte(8'h11, a); chk(a == 1, "R3 data ack", a, 1);
    send_byte(8'h22, a); chk(a == 1, "R3 data ack", a, 1);
    do_stop;

    // read back through a repeated START
    do_start;
    send_byte(8'h90, a);
    send_byte(8'h01, a);
    do_start;
    send_byte(8'h91, a); chk(a == 1, "R1 rstart read ack", a, 1);
    recv_byte(1, d); chk(d == 8'h11, "R5 read 1", d, 8'h11);
    recv_byte(1, d); chk(d == 8'h22, "R5 read 2", d, 8'h22);
    recv_byte(0, d); chk(d == 8'hA3, "R5 read 3", d, 8'hA3);
    recv_byte(0, d); chk(d == 8'hFF, "R6 silent after nack", d, 8'hFF);
    chk(sda_oe == 1'b0, "R6 released", sda_oe, 0);
    do_stop;

    // pointer wrap
    do_start;
    send_byte(8'h90, a); send_byte(8'h03, a);
    send_byte(8'h33, a); send_byte(8'h44, a);
    chk(a == 1, "R7 wrap write ack", a, 1);
    do_stop;
    do_start;
    send_byte(8'h90, a); send_byte(8'h03, a);
    do_start;
    send_byte(8'h91, a);
    recv_byte(1, d); chk(d == 8'h33, "R7 reg3", d, 8'h33);
    recv_byte(0, d); chk(d == 8'h44, "R7 wrapped reg0", d, 8'h44);
    do_stop;

    // foreign address
    do_start;
    send_byte(8'h92, a); chk(a == 0, "R4 no ack", a, 0);
    send_byte(8'h00, a); chk(a == 0, "R4 ignored byte", a, 0);
    do_stop;

    // pins change: no effect until general call latch
    pins = 7'h21;
    w(4);
    do_start;
    send_byte(8'h90, a); chk(a == 1, "R13 old addr kept", a, 1);
    do_stop;
    do_start;
    send_byte(8'h00, a); chk(a == 1, "R8 gc ack", a, 1);
    send_byte(8'h04, a); chk(a == 1, "R8 cmd ack", a, 1);
    do_stop;
    do_start;
    send_byte(8'h90, a); chk(a == 0, "R8 old addr dropped", a, 0);
    do_stop;
    do_start;
    send_byte(8'h42, a); chk(a == 1, "R8 new addr", a, 1);
    send_byte(8'h00, a);
    do_start;
    send_byte(8'h43, a);
    recv_byte(0, d); chk(d == 8'h44, "R8 regs kept", d, 8'h44);
    do_stop;

    // latch and reset
    pins = 7'h35;
    w(4);
    do_start;
    send_byte(8'h00, a);
    send_byte(8'h06, a); chk(a == 1, "R9 cmd ack", a, 1);
    do_stop;
    do_start;
    send_byte(8'h6B, a); chk(a == 1, "R9 latched addr", a, 1);
    recv_byte(1, d); chk(d == 8'hA0, "R9 reg0 default", d, 8'hA0);
    recv_byte(0, d); chk(d == 8'hA1, "R9 reg1 default", d, 8'hA1);
    do_stop;

    // high-speed master code
    mon_hold = 1'b1;
    do_start;
    send_byte(8'h08, a); chk(a == 0, "R10 code not acked", a, 0);
    hs_model = 1'b1;
    w(4);
    mon_hold = 1'b0;
    chk(hs_mode == 1'b1, "R10 hs set", hs_mode, 1);
    do_start;
    send_byte(8'h6A, a); chk(a == 1, "R11 addr in hs", a, 1);
    send_byte(8'h02, a); send_byte(8'h55, a);
    chk(hs_mode == 1'b1, "R11 hs held", hs_mode, 1);
    do_stop;
    chk(hs_mode == 1'b0, "R11 hs cleared", hs_mode, 0);
    do_start;
    send_byte(8'h6A, a); send_byte(8'h02, a);
    do_start;
    send_byte(8'h6B, a);
    recv_byte(0, d); chk(d == 8'h55, "R3 hs write stored", d, 8'h55);
    do_stop;

    mon_hold = 1'b1;
    do_start;
    send_byte(8'h0F, a); chk(a == 0, "R10 code 0F not acked", a, 0);
    hs_model = 1'b1;
    w(4);
    mon_hold = 1'b0;
    chk(hs_mode == 1'b1, "R10 hs set 0F", hs_mode, 1);
    do_stop;
    chk(hs_mode == 1'b0, "R11 cleared 0F", hs_mode, 0);

    total += 2;  // per-clock R11 and R12 monitors
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule